// File: doc/BRIEF.md
# UART Baud Tick Generator with Fractional Prescaler

This block derives the two timing strobes a 16550-style serial port needs from one fixed input clock. The clock first passes through an optional prescaler. The prescaler divides by a fixed-point value with eighth-step resolution. A 16-bit integer divisor follows, and then an oversampling counter whose ratio can be set from 4 to 16. The divisor output is the sample strobe, which the receive and transmit shift logic use. The oversampling counter groups those samples into a bit strobe.

Software programs the block through a narrow write-only port with six byte registers. Any write to one of these registers restarts the whole chain, so the new rate begins from a clean phase. The long-run bit rate is the input clock divided by (prescale × divisor × ratio). With every stage at its minimum, the bit rate is one quarter of the input clock.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 1, the prescaler is 1.000 and disabled, and the ratio is 16. The sample strobe is therefore high in every cycle, and the bit strobe is high on every 16th sample. Both strobes are low while reset is held.
- R2: Register addresses, with the value taken from wr_data:
  - 0: divisor low byte.
  - 1: divisor high byte.
  - 2: ratio, in bits 4:0.
  - 3: prescaler integer part, in bits 5:0.
  - 4: prescaler fraction in eighths, in bits 2:0.
  - 5: prescaler enable, in bit 7.
  
  Writes to addresses 6 and 7 change nothing and do not restart the counters.
- R3: Let Q be the effective divisor times the effective prescale in eighths. Count clock edges after the restarting edge, with n = 1 for the first. The sample strobe is high in the cycle that follows edge n exactly when floor(8n/Q) > floor(8(n-1)/Q).
- R4: When the enable bit is clear, the prescaler acts as a divide-by-1 (8 eighths), whatever its integer and fraction registers hold.
- R5: A prescaler integer part of 0 gives a prescale of exactly 1.000, and the fraction is then ignored. A divisor of 0 acts as 1.
- R6: A ratio below 4 acts as 4, and a ratio above 16 acts as 16. The bit strobe fires once per N sample strobes, where N is the clamped ratio.
- R7: The bit strobe is high only together with a sample strobe. It marks the sample whose index since the restart is a multiple of N, so the first bit strobe comes on sample N.
- R8: A write to addresses 0 to 5 restarts all counters. In the cycle after the write edge both strobes are low, and the strobes after that follow R3 with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | Oversampling-rate strobe, one clock wide |
| bit_tick | output | 1 | Bit-rate strobe, one clock wide |

## Verification
The checker assumes that writes come as single-cycle strobes, and that the strobes are judged only against the settings in force since the last restart. Because of this, each register write resets its own sample-group count. It also assumes the register contents are stable between writes. The bench keeps to this by driving the write port for exactly one cycle per access, and by releasing it on the falling edge. Random configurations keep the divisor small, so that every run sees several complete bit groups. Directed cases cover the zero clamps, the ratio extremes, a divisor of 256, a write to an unused address in the middle of a run, and a restart in the middle of a stream.

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen #(
  parameter int DIV_W   = 16,
  parameter int INT_W   = 6,
  parameter int FRAC_W  = 3,
  parameter int OSR_W   = 5,
  parameter int OSR_MIN = 4,
  parameter int OSR_MAX = 16,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int PRE_W  = INT_W + FRAC_W;
  localparam int ACC_W  = PRE_W + 1;
  localparam int STEP   = 1 << FRAC_W;
  localparam int EN_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OSR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PINT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PFRC = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5);

  logic [DIV_W-1:0]  div_q;
  logic [OSR_W-1:0]  osr_q;
  logic [INT_W-1:0]  pint_q;
  logic [FRAC_W-1:0] pfrac_q;
  logic              pre_on_q;

  logic [ACC_W-1:0]  acc_q;
  logic [DIV_W-1:0]  div_cnt_q;
  logic [OSR_W-1:0]  osr_cnt_q;

  logic              hit;
  logic [PRE_W-1:0]  pre_val;
  logic [DIV_W-1:0]  div_eff;
  logic [OSR_W-1:0]  osr_eff;
  logic [ACC_W-1:0]  acc_nxt;
  logic              pre_tick;
  logic              div_last;
  logic              osr_last;
  logic              samp;

  assign hit = wr_en && (wr_addr <= A_CTRL);

  assign pre_val  = (pint_q == '0) ? PRE_W'(STEP) : {pint_q, pfrac_q};
  assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
  assign osr_eff  = (osr_q < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_MIN) :
                    (osr_q > OSR_W'(OSR_MAX)) ? OSR_W'(OSR_MAX) : osr_q;
  assign acc_nxt  = acc_q + ACC_W'(STEP);
  assign pre_tick = !pre_on_q || (acc_nxt >= {1'b0, pre_val});
  assign div_last = (div_cnt_q == div_eff - DIV_W'(1));
  assign osr_last = (osr_cnt_q == osr_eff - OSR_W'(1));
  assign samp     = pre_tick && div_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(1);
      osr_q    <= OSR_W'(OSR_MAX);
      pint_q   <= INT_W'(1);
      pfrac_q  <= '0;
      pre_on_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIVL: div_q[DATA_W-1:0]     <= wr_data;
        A_DIVH: div_q[DIV_W-1:DATA_W] <= wr_data[DIV_W-DATA_W-1:0];
        A_OSR:  osr_q                 <= wr_data[OSR_W-1:0];
        A_PINT: pint_q                <= wr_data[INT_W-1:0];
        A_PFRC: pfrac_q               <= wr_data[FRAC_W-1:0];
        A_CTRL: pre_on_q              <= wr_data[EN_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hit) begin
      acc_q       <= '0;
      div_cnt_q   <= '0;
      osr_cnt_q   <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      if (pre_on_q)
        acc_q <= pre_tick ? acc_nxt - {1'b0, pre_val} : acc_nxt;
      if (pre_tick)
        div_cnt_q <= div_last ? '0 : div_cnt_q + DIV_W'(1);
      if (samp)
        osr_cnt_q <= osr_last ? '0 : osr_cnt_q + OSR_W'(1);
      sample_tick <= samp;
      bit_tick    <= samp && osr_last;
    end
  end
endmodule

module baud_tick_gen_chk #(
  parameter int DIV_W   = 16,
  parameter int OSR_W   = 5,
  parameter int OSR_MIN = 4,
  parameter int OSR_MAX = 16,
  parameter int ADDR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sample_tick,
  input logic              bit_tick,
  input logic [DIV_W-1:0]  div_q,
  input logic [OSR_W-1:0]  osr_q,
  input logic              pre_on_q
);
  logic             restart;
  logic [OSR_W-1:0] grp;
  logic [OSR_W-1:0] n_eff;

  assign restart = wr_en && (wr_addr <= ADDR_W'(5));
  assign n_eff   = (osr_q < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_MIN) :
                   (osr_q > OSR_W'(OSR_MAX)) ? OSR_W'(OSR_MAX) : osr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) grp <= '0;
    else if (bit_tick)     grp <= '0;
    else if (sample_tick)  grp <= grp + OSR_W'(1);
  end

  p_bit_with_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_bit_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (grp == n_eff - OSR_W'(1)));

  p_group_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !bit_tick) |-> (grp < n_eff - OSR_W'(1)));

  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_tick && !bit_tick));

  p_sample_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !pre_on_q && div_q > DIV_W'(1)) |=> !sample_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
  .DIV_W(DIV_W), .OSR_W(OSR_W), .OSR_MIN(OSR_MIN), .OSR_MAX(OSR_MAX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sample_tick(sample_tick), .bit_tick(bit_tick),
  .div_q(div_q), .osr_q(osr_q), .pre_on_q(pre_on_q)
);

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit done = 0;

  logic [7:0] sh_dl = 8'd1, sh_dh = 8'd0;
  logic [4:0] sh_osr = 5'd16;
  logic [5:0] sh_pi = 6'd1;
  logic [2:0] sh_pf = 3'd0;
  logic       sh_en = 1'b0;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #10 clk = ~clk;

  function automatic int calc_q();
    int d, p;
    d = {sh_dh, sh_dl};
    if (d == 0) d = 1;
    if (!sh_en)          p = 8;
    else if (sh_pi == 0) p = 8;
    else                 p = int'(sh_pi) * 8 + int'(sh_pf);
    return d * p;
  endfunction

  function automatic int calc_n();
    if (sh_osr < 4)  return 4;
    if (sh_osr > 16) return 16;
    return int'(sh_osr);
  endfunction

  function automatic logic [1:0] expect_ticks(int k);
    int q, a, b;
    logic s;
    if (k == 0) return 2'b00;
    q = calc_q();
    a = (8 * k) / q;
    b = (8 * (k - 1)) / q;
    s = (a > b);
    return {s, s && (a % calc_n() == 0)};
  endfunction

  task automatic check(string tag);
    logic [1:0] e;
    e = expect_ticks(n);
    checks++;
    if ({sample_tick, bit_tick} !== e) begin
      errors++;
      $display("FAIL %s n=%0d actual=%b expected=%b", tag, n, {sample_tick, bit_tick}, e);
    end
  endtask

  task automatic run(int k, string tag);
    repeat (k) begin
      @(negedge clk);
      n++;
      check(tag);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    case (a)
      3'd0: sh_dl = d;
      3'd1: sh_dh = d;
      3'd2: sh_osr = d[4:0];
      3'd3: sh_pi = d[5:0];
      3'd4: sh_pf = d[2:0];
      3'd5: sh_en = d[7];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    if (a <= 3'd5) n = 0; else n++;
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
        errors++;
        $display("FAIL R1 in reset actual=%b expected=00", {sample_tick, bit_tick});
      end
    end
    rst_n = 1'b1;
    n = 0;
    check("R1");
    run(40, "R1");

    wr(3'd2, 8'd4, "R6");
    wr(3'd5, 8'h80, "R3");
    run(20, "R3 minimum rate");

    wr(3'd2, 8'd0, "R6");
    run(20, "R6 low clamp");
    wr(3'd2, 8'd31, "R6");
    run(40, "R6 high clamp");

    wr(3'd0, 8'd0, "R5");
    run(20, "R5 divisor zero");

    wr(3'd3, 8'd0, "R5");
    wr(3'd4, 8'd5, "R5");
    run(20, "R5 prescale zero");

    wr(3'd2, 8'd5, "R7");
    wr(3'd3, 8'd2, "R3");
    wr(3'd4, 8'd3, "R3");
    wr(3'd0, 8'd3, "R3");
    run(300, "R3 fractional");

    wr(3'd3, 8'd5, "R4");
    wr(3'd5, 8'h00, "R4");
    run(100, "R4 bypass");

    wr(3'd0, 8'd5, "R2");
    run(7, "R2");
    wr(3'd6, 8'hFF, "R2 unmapped");
    run(13, "R2");
    wr(3'd7, 8'h00, "R2 unmapped");
    run(20, "R2");

    wr(3'd0, 8'd7, "R8");
    run(10, "R8");
    wr(3'd0, 8'd7, "R8 restart");
    run(40, "R8");

    wr(3'd2, 8'd4, "R3");
    wr(3'd0, 8'd0, "R3");
    wr(3'd1, 8'd1, "R3");
    run(4 * 2048 + 10, "R3 divisor 256");
    wr(3'd1, 8'd0, "R3");

    for (int i = 0; i < 60; i++) begin
      wr(3'd0, 8'($urandom_range(0, 15)), "R3 random");
      wr(3'd2, 8'($urandom_range(0, 31)), "R6 random");
      wr(3'd3, 8'($urandom_range(0, 12)), "R5 random");
      wr(3'd4, 8'($urandom_range(0, 7)), "R3 random");
      wr(3'd5, ($urandom_range(0, 1) != 0) ? 8'h80 : 8'h00, "R4 random");
      run(300, "R7 random");
    end

    finish_run();
  end
endmodule